// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protect Guard

This block holds the status register of a small serial EEPROM and decides, cycle by cycle, whether a write to the memory array or to the status register may proceed. A command decoder outside the block hands it one-cycle strobes: set latch, clear latch, status write, status read and array write. It also receives the write-protect pin, the busy flag of the internal write engine and the target array address. The block returns the status byte, a permit for array writes and a permit for status writes.

The status byte carries a busy flag, a volatile write-enable latch and two block-protect bits that fence off an upper fraction of the array. The latch must be set again before every write, because any accepted write clears it. The parameter `MEM_BYTES` picks a 256-byte or a 512-byte array, and the protected ranges scale with it. All ports are plain control and status signals. The permits are single-cycle decisions with no handshake, so there is no back-pressure.

Top module: `eeprom_status_guard`

## Requirements
- R1: While idle, the status byte reads {4'b0000, bp[1:0], wel, 1'b0}. Bit 0 is the busy flag, bit 1 is the write-enable latch, and bits 3:2 are the block-protect field with its upper bit at bit 3. Bits 7:4 read 0.
- R2: While `busy` is 1, the status byte reads 8'hFF.
- R3: While `busy` is 1, set-latch, clear-latch, status-write and array-write strobes have no effect and both permits stay 0. A status-read strobe still raises `status_rd_valid` in the same cycle.
- R4: Only a set-latch strobe while idle sets the latch. The new value shows in the status byte one cycle later.
- R5: The latch reads 0 after reset. It also reads 0 in the cycle after any of these: a clear-latch strobe, an accepted array write, an accepted status write, or `wp_n` low. Clearing has priority over setting.
- R6: `status_write_ok` is 1 exactly when a status-write strobe arrives while idle, with the latch at 1 and `wp_n` at 1. In the next cycle bp takes data bits 3:2. Data bits 7:4, 1 and 0 are ignored.
- R7: `array_write_ok` is 1 exactly when an array-write strobe arrives while idle, with the latch at 1 and the address outside the protected range. A refused write leaves the latch unchanged.
- R8: The bp code sets the protected range. 00 protects nothing, 01 the top quarter, 10 the top half and 11 the whole array. For 256 bytes these ranges are C0h–FFh, 80h–FFh and 00h–FFh.
- R9: bp resets to 00 and keeps its value whenever the latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_set_wel | input | 1 | Set-latch command strobe |
| cmd_clr_wel | input | 1 | Clear-latch command strobe |
| cmd_stat_wr | input | 1 | Status-write command strobe |
| cmd_stat_rd | input | 1 | Status-read command strobe |
| cmd_arr_wr | input | 1 | Array-write command strobe |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write cycle in progress |
| arr_addr | input | AW | Target array address |
| stat_wdata | input | 8 | Data byte for a status write |
| status_byte | output | 8 | Status byte read-back |
| status_rd_valid | output | 1 | Status-read strobe accepted |
| array_write_ok | output | 1 | Array write permitted this cycle |
| status_write_ok | output | 1 | Status write permitted this cycle |

## Verification
The hardest state to reach is a latch that is set while the engine is busy, so that the stimulus can show busy-time commands are really ignored rather than merely masked by the all-ones read-back. The bench sets the latch while idle, raises `busy`, issues clear-latch and write strobes, drops `busy` and reads the latch back through the status byte. The range edges get the same care. The bench programs each bp code through a real status write, sets the latch again and probes the address on each side of the boundary. It then confirms that a refused write left the latch set.

// File: rtl/eeprom_prot_pkg.sv
package eeprom_prot_pkg;
  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_level_e;

  localparam int STAT_W   = 8;
  localparam int BP_LO    = 2;
  localparam int WEL_BIT  = 1;
  localparam int BUSY_BIT = 0;
endpackage

// File: rtl/wel_latch.sv
module wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic wp_n_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic arr_acc_i,
  input  logic stat_acc_i,
  output logic wel_o
);
  logic clear_now;
  assign clear_now = !wp_n_i || (!busy_i && (clr_i || arr_acc_i || stat_acc_i));

  always_ff @(posedge clk) begin
    if (!rst_n)             wel_o <= 1'b0;
    else if (clear_now)     wel_o <= 1'b0;
    else if (!busy_i && set_i) wel_o <= 1'b1;
  end

  // R4
  wel_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_o) |-> $past(set_i && !busy_i));

  // R5
  wel_wp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n_i |=> !wel_o);
endmodule

// File: rtl/bp_store.sv
module bp_store
  import eeprom_prot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [7:0]  data_i,
  output prot_level_e level_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      level_o <= PROT_NONE;
    else if (load_i) level_o <= prot_level_e'(data_i[BP_LO +: 2]);
  end

  // R6
  bp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> level_o == $past(data_i[BP_LO +: 2]));

  // R9
  bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(level_o));
endmodule

// File: rtl/range_guard.sv
module range_guard
  import eeprom_prot_pkg::*;
#(
  parameter int AW = 8
) (
  input  prot_level_e    level_i,
  input  logic [AW-1:0]  addr_i,
  output logic           locked_o
);
  always_comb begin
    unique case (level_i)
      PROT_NONE:    locked_o = 1'b0;
      PROT_QUARTER: locked_o = &addr_i[AW-1 -: 2];
      PROT_HALF:    locked_o = addr_i[AW-1];
      default:      locked_o = 1'b1;
    endcase
  end

  // R8
  always_comb begin
    if (level_i == PROT_ALL) range_all_chk: assert (locked_o);
    if (level_i == PROT_NONE) range_none_chk: assert (!locked_o);
  end
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import eeprom_prot_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_set_wel,
  input  logic          cmd_clr_wel,
  input  logic          cmd_stat_wr,
  input  logic          cmd_stat_rd,
  input  logic          cmd_arr_wr,
  input  logic          wp_n,
  input  logic          busy,
  input  logic [AW-1:0] arr_addr,
  input  logic [7:0]    stat_wdata,
  output logic [7:0]    status_byte,
  output logic          status_rd_valid,
  output logic          array_write_ok,
  output logic          status_write_ok
);
  logic        wel;
  logic        locked;
  prot_level_e level;

  generate
    if (MEM_BYTES != 256 && MEM_BYTES != 512) begin : g_bad_size
      initial size_param_chk: assert (0);
    end
  endgenerate

  assign array_write_ok  = cmd_arr_wr && !busy && wel && !locked;
  assign status_write_ok = cmd_stat_wr && !busy && wel && wp_n;
  assign status_rd_valid = cmd_stat_rd;

  always_comb begin
    if (busy) status_byte = '1;
    else begin
      status_byte                = '0;
      status_byte[BP_LO +: 2]    = level;
      status_byte[WEL_BIT]       = wel;
      status_byte[BUSY_BIT]      = 1'b0;
    end
  end

  wel_latch u_wel (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .wp_n_i(wp_n),
    .set_i(cmd_set_wel), .clr_i(cmd_clr_wel),
    .arr_acc_i(array_write_ok), .stat_acc_i(status_write_ok),
    .wel_o(wel)
  );

  bp_store u_bp (
    .clk(clk), .rst_n(rst_n), .load_i(status_write_ok),
    .data_i(stat_wdata), .level_o(level)
  );

  range_guard #(.AW(AW)) u_rng (
    .level_i(level), .addr_i(arr_addr), .locked_o(locked)
  );

  // R3
  busy_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !array_write_ok && !status_write_ok);

  // R7
  arr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_write_ok |-> status_byte[WEL_BIT]);

  // R5
  arr_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_write_ok |=> !wel);
endmodule

// File: tb/eeprom_status_guard_test.sv
module eeprom_status_guard_test;
  logic clk = 0;
  logic rst_n = 0;
  logic set_w = 0, clr_w = 0, swr = 0, srd = 0, awr = 0;
  logic wp_n = 1, busy = 0;
  logic [7:0] addr = 0, wdat = 0;
  logic [7:0] stat;
  logic rdv, aok, sok;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  eeprom_status_guard #(.MEM_BYTES(256)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_set_wel(set_w), .cmd_clr_wel(clr_w),
    .cmd_stat_wr(swr), .cmd_stat_rd(srd), .cmd_arr_wr(awr), .wp_n(wp_n),
    .busy(busy), .arr_addr(addr), .stat_wdata(wdat), .status_byte(stat),
    .status_rd_valid(rdv), .array_write_ok(aok), .status_write_ok(sok)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one cycle of strobes; capture permits before the edge, return after it.
  task automatic issue(input logic s, input logic c, input logic sw, input logic aw,
                       input logic [7:0] a, input logic [7:0] d,
                       output logic a_ok, output logic s_ok);
    @(negedge clk);
    set_w = s; clr_w = c; swr = sw; awr = aw; addr = a; wdat = d;
    #1 a_ok = aok; s_ok = sok;
    @(negedge clk);
    set_w = 0; clr_w = 0; swr = 0; awr = 0;
  endtask

  task automatic set_bp(input logic [1:0] v);
    logic x, y;
    issue(1, 0, 0, 0, 0, 0, x, y);
    issue(0, 0, 1, 0, 0, {4'hA, v, 2'b11}, x, y);
  endtask

  task automatic t_reset();
    logic x, y;
    check("R1 reset status", stat, 8'h00);
    issue(0, 0, 0, 1, 8'h10, 0, x, y);
    check("R7 write without latch", {7'b0, x}, 8'h00);
    issue(0, 0, 1, 0, 0, 8'h0C, x, y);
    check("R6 status write without latch", {7'b0, y}, 8'h00);
    check("R9 bp after reset", stat, 8'h00);
  endtask

  task automatic t_latch();
    logic x, y;
    issue(1, 0, 0, 0, 0, 0, x, y);
    check("R4 latch set", stat, 8'h02);
    issue(0, 1, 0, 0, 0, 0, x, y);
    check("R5 clear strobe", stat, 8'h00);
    issue(1, 1, 0, 0, 0, 0, x, y);
    check("R5 clear beats set", stat, 8'h00);
  endtask

  task automatic t_array();
    logic x, y;
    issue(1, 0, 0, 0, 0, 0, x, y);
    issue(0, 0, 0, 1, 8'h10, 0, x, y);
    check("R7 permitted write", {7'b0, x}, 8'h01);
    check("R5 clear after array write", stat, 8'h00);
  endtask

  task automatic t_status_write();
    logic x, y;
    issue(1, 0, 0, 0, 0, 0, x, y);
    issue(0, 0, 1, 0, 0, 8'hF7, x, y);
    check("R6 status write permit", {7'b0, y}, 8'h01);
    check("R6 R1 only bp updated, latch cleared", stat, 8'h04);
  endtask

  task automatic probe(input string req, input logic [7:0] a, input logic exp_ok,
                       input logic [7:0] exp_stat);
    logic x, y;
    issue(1, 0, 0, 0, 0, 0, x, y);
    issue(0, 0, 0, 1, a, 0, x, y);
    check(req, {7'b0, x}, {7'b0, exp_ok});
    check({req, " latch after"}, stat, exp_stat);
  endtask

  task automatic t_ranges();
    set_bp(2'b01);
    probe("R8 quarter BFh", 8'hBF, 1, 8'h04);
    probe("R8 quarter C0h", 8'hC0, 0, 8'h06);
    set_bp(2'b10);
    probe("R8 half 7Fh", 8'h7F, 1, 8'h08);
    probe("R8 half 80h", 8'h80, 0, 8'h0A);
    set_bp(2'b11);
    probe("R8 all 00h", 8'h00, 0, 8'h0E);
    set_bp(2'b00);
    probe("R8 none FFh", 8'hFF, 1, 8'h00);
  endtask

  task automatic t_wp();
    logic x, y;
    issue(1, 0, 0, 0, 0, 0, x, y);
    @(negedge clk); wp_n = 0;
    @(negedge clk);
    check("R5 wp low clears latch", stat, 8'h00);
    issue(1, 0, 1, 0, 0, 8'h0C, x, y);
    check("R6 status write refused with wp low", {7'b0, y}, 8'h00);
    check("R5 set ignored while wp low", stat, 8'h00);
    wp_n = 1;
    issue(1, 0, 0, 0, 0, 0, x, y);
    @(negedge clk); wp_n = 0; swr = 1; wdat = 8'h0C;
    #1 check("R6 same-cycle wp low refuses", {7'b0, sok}, 8'h00);
    @(negedge clk); swr = 0; wp_n = 1;
    check("R9 bp kept", stat, 8'h00);
  endtask

  task automatic t_busy();
    logic x, y;
    set_bp(2'b10);
    issue(1, 0, 0, 0, 0, 0, x, y);
    @(negedge clk); busy = 1;
    #1 check("R2 busy read-back", stat, 8'hFF);
    srd = 1;
    #1 check("R3 read strobe while busy", {7'b0, rdv}, 8'h01);
    srd = 0;
    issue(0, 1, 0, 0, 0, 0, x, y);
    issue(0, 0, 1, 1, 8'h00, 8'h00, x, y);
    check("R3 array permit while busy", {7'b0, x}, 8'h00);
    check("R3 status permit while busy", {7'b0, y}, 8'h00);
    busy = 0;
    #1 check("R3 latch and bp survived busy", stat, 8'h0A);
    issue(0, 1, 0, 0, 0, 0, x, y);
    check("R9 bp kept after latch clear", stat, 8'h08);
    issue(1, 0, 0, 0, 0, 0, x, y);
    @(negedge clk); busy = 1;
    @(negedge clk); busy = 0; set_w = 0;
    #1 check("R4 latch not touched by busy alone", stat, 8'h0A);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check("R9 reset returns bp to 00", stat, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_latch();
        t_array();
        t_status_write();
        t_ranges();
        t_wp();
        t_busy();
      end
      begin
        repeat (20000) @(posedge clk);
        runs++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule